// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block is a single DMA channel engine. Software programs it through a small register window. The low part of that window is an on-chip instruction store. Every stored instruction holds eight words, and each word is kept with an even-parity bit. Above the store sit the channel's own registers: a 16-bit mode word, a remaining-word count, two area addresses with their extension words, and a status word. Writing the mode word with its top bit set starts the channel. The engine then moves words over a simple request/acknowledge bus until the remaining count reaches zero.

Each transfer mode gives a different bus pattern. Single, double and burst modes work from area 1 alone and are paced by a device request input. Area-to-area modes need no pacing: they read from area 1 and write the same data to area 2. At the end of a block the channel does one of two things. If chaining is enabled and the 6-bit pointer names a valid instruction, it copies that stored instruction into its registers and carries on. Otherwise it stops. A one-cycle end-of-transfer strobe marks the end of the block when chaining is off, or always when the force bit is set. A parity fault while copying an instruction stops the channel with an error flag.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset the mode word reads 0x0000, the status word reads 0x0000, and bus_req and eot are low.
- R2: Writing the mode word (window word 0x1E0) with bit 15 set starts the channel, and bit 15 then reads 1. The transfer-mode field is bits 14:12. If that field is 011, bit 15 reads 0 and no bus cycle follows. Writing bit 15 as 0 stops the channel, and it makes no further bus cycles.
- R3: Transfer mode 000 (single) makes exactly one bus cycle per device request, at the area 1 address. The area 1 field is bits 11:10. Its bit 11 gives bus_we: 0 reads from memory and 1 writes to memory. Its bit 10 gives the address step: 0 adds one after each word and 1 subtracts one.
- R4: In transfer mode 001 (double), each device request gives two bus cycles, and the remaining count (word 0x1E1) drops by two.
- R5: In transfer mode 010 (burst), one device request starts a run of bus cycles that continues until the remaining count reaches zero.
- R6: Transfer modes 1xx (area to area) need no device request. Each word is a read at the area 1 address followed by a write at the area 2 address that carries the data just read. Mode bit 13 is the IO flag of the read, and mode bit 12 is the IO flag of the write. In these modes each area field works the same way: 01 adds one, 10 subtracts one, and 00 or 11 holds the address. The area 2 field is bits 9:8.
- R7: The channel reaches the end of a block when the remaining count is zero. It then pulses eot for exactly one cycle in two cases: the force bit (bit 7) is 1, or the block will not chain. If it does not chain, bit 15 clears and status bit 1 is set.
- R8: The channel chains only when the chain bit (bit 6) is 1 and the pointer (bits 5:0) is below 0x3C. Chaining copies store words ptr*8+0 to ptr*8+5 into the mode, count, area 1 address, area 1 extension, area 2 address and area 2 extension registers. The channel then runs the copied block. Pointers 0x3C to 0x3F, or a chain bit of 0, end the run.
- R9: A fetched store word whose 17 bits have odd parity sets status bit 0 and clears mode bit 15. No further bus cycle follows.
- R10: Window words 0x000 to 0x1DF read back what was written to them. Words 0x1E0 to 0x1E6 are the channel registers. All other words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 9 | Register window word address |
| reg_we | input | 1 | Register window write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_wpar | input | 1 | Even-parity bit stored with an instruction word |
| reg_rdata | output | 16 | Register read data (combinational) |
| dev_req | input | 1 | Device pacing request for single, double and burst modes |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_we | output | 1 | Bus cycle is a write |
| bus_io | output | 1 | Bus cycle targets IO space |
| bus_addr | output | 16 | Bus cycle address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with bus_ack |
| bus_ack | input | 1 | Bus cycle acknowledge |
| eot | output | 1 | End-of-transfer strobe |

## Verification
The bound checker watches four things on every cycle. Bus requests only appear while the channel is active. The end-of-transfer strobe lasts one cycle and comes only with a zero remaining count. No bus cycle follows straight after that strobe. The scenarios are needed for everything else: the address order of each transfer mode and each area setting, the data carried in area-to-area transfers, pacing by device requests, the contents copied by a chain, reserved pointers and the chain override, and the stop that follows a parity fault.

// File: rtl/chain_dma_pkg.sv
// Shared types for the chained DMA channel.
// Assumes: 3-bit transfer-mode field and 2-bit area fields in the mode word.
package chain_dma_pkg;
    typedef enum logic [1:0] {STEP_HOLD, STEP_INC, STEP_DEC} step_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_XFER, ST_SRC, ST_DST, ST_FETCH
    } state_e;

    localparam logic [2:0] XM_SINGLE = 3'b000;
    localparam logic [2:0] XM_DOUBLE = 3'b001;
    localparam logic [2:0] XM_BURST  = 3'b010;
    localparam logic [2:0] XM_NONE   = 3'b011;

    // Address behaviour of an area field in area-to-area modes.
    function automatic step_e area_step(input logic [1:0] f);
        case (f)
            2'b01:   return STEP_INC;
            2'b10:   return STEP_DEC;
            default: return STEP_HOLD;
        endcase
    endfunction
endpackage

// File: rtl/chain_dma_store.sv
// Instruction store with even parity per word.
// It has one write port and two combinational read ports: a host port and a
// fetch port, and the fetch port also flags a parity fault.
// Assumes: the writer supplies the parity bit; memory contents are not reset.
module chain_dma_store #(
    parameter int DW    = 16,
    parameter int WORDS = 480,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_par,
    input  logic [AW-1:0] rd_a_addr,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_bad
);
    localparam logic [AW-1:0] LIM = AW'(WORDS);

    logic [DW:0] mem [WORDS];
    logic [DW:0] word_b;

    // Store a data word with its parity bit.
    always_ff @(posedge clk) begin
        if (wr_en && wr_addr < LIM) mem[wr_addr] <= {wr_par, wr_data};
    end

    // Host read port, data only.
    always_comb rd_a_data = (rd_a_addr < LIM) ? mem[rd_a_addr][DW-1:0] : '0;

    // Fetch read port with parity check.
    always_comb begin
        word_b    = (rd_b_addr < LIM) ? mem[rd_b_addr] : '0;
        rd_b_data = word_b[DW-1:0];
        rd_b_bad  = ^word_b;
    end
endmodule

// File: rtl/chain_dma_step.sv
// Next-address computation for one area: hold, add one or subtract one.
module chain_dma_step import chain_dma_pkg::*; #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  step_e         dir_i,
    output logic [AW-1:0] addr_o
);
    // Select the stepped address.
    always_comb begin
        case (dir_i)
            STEP_INC: addr_o = addr_i + AW'(1);
            STEP_DEC: addr_o = addr_i - AW'(1);
            default:  addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/chain_dma_chan.sv
// Chained DMA channel sequencer.
// It decodes the register window (instruction store plus channel registers),
// runs single, double, burst and area-to-area transfers over a req/ack bus,
// and at the end of each block either signals end of transfer or chains to
// a stored instruction.
// Assumes: data and address words share width DW; host writes win over the
// engine's own updates in the same cycle; one bus cycle in flight at a time.
module chain_dma_chan import chain_dma_pkg::*; #(
    parameter int DW         = 16,
    parameter int NUM_INSTR  = 60,
    parameter int WPI        = 8,
    parameter int LOAD_WORDS = 6,
    parameter int REG_AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_wpar,
    output logic [DW-1:0]     reg_rdata,
    input  logic              dev_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_io,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic              eot
);
    localparam int                STORE_WORDS = NUM_INSTR * WPI;
    localparam logic [REG_AW-1:0] CTRL_BASE   = REG_AW'(STORE_WORDS);
    localparam logic [5:0]        PTR_LIMIT   = 6'(NUM_INSTR);
    localparam int                FI_W        = $clog2(WPI);
    localparam logic [FI_W-1:0]   LAST_FI     = FI_W'(LOAD_WORDS - 1);

    state_e          state_q;
    logic [DW-1:0]   mode_q, remain_q, hold_q;
    logic [DW-1:0]   addr_q [2];
    logic [DW-1:0]   ext_q  [2];
    logic [DW-1:0]   addr_nx[2];
    step_e           dir    [2];
    logic [1:0]      stat_q;
    logic            pair_q, seen_q;
    logic [FI_W-1:0] fidx_q;
    logic [5:0]      fptr_q;

    logic [2:0]        xm;
    logic              area_x, chain_ok, blk_end, is_store, start_ok;
    logic [REG_AW-1:0] ctrl_off, fetch_addr;
    logic [DW-1:0]     store_rd, fetch_data;
    logic              fetch_bad;

    // Mode-word field decode and block-end conditions.
    always_comb begin
        xm       = mode_q[14:12];
        area_x   = xm[2];
        chain_ok = mode_q[6] && (mode_q[5:0] < PTR_LIMIT);
        blk_end  = (state_q == ST_ARM) && (remain_q == '0);
        eot      = blk_end && (mode_q[7] || !chain_ok);
        dir[0]   = area_x ? area_step(mode_q[11:10])
                          : (mode_q[10] ? STEP_DEC : STEP_INC);
        dir[1]   = area_x ? area_step(mode_q[9:8]) : STEP_HOLD;
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_area
            chain_dma_step #(.AW(DW)) u_step (
                .addr_i(addr_q[g]), .dir_i(dir[g]), .addr_o(addr_nx[g])
            );
        end
    endgenerate

    // Register window decode and fetch address.
    always_comb begin
        is_store   = reg_addr < CTRL_BASE;
        ctrl_off   = reg_addr - CTRL_BASE;
        start_ok   = reg_wdata[15] && (reg_wdata[14:12] != XM_NONE);
        fetch_addr = REG_AW'(fptr_q) * REG_AW'(WPI) + REG_AW'(fidx_q);
    end

    chain_dma_store #(.DW(DW), .WORDS(STORE_WORDS), .AW(REG_AW)) u_store (
        .clk(clk), .wr_en(reg_we && is_store), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .wr_par(reg_wpar),
        .rd_a_addr(reg_addr), .rd_a_data(store_rd),
        .rd_b_addr(fetch_addr), .rd_b_data(fetch_data), .rd_b_bad(fetch_bad)
    );

    // Host read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (is_store) reg_rdata = store_rd;
        else if (ctrl_off[REG_AW-1:3] == '0) begin
            case (ctrl_off[2:0])
                3'd0: reg_rdata = mode_q;
                3'd1: reg_rdata = remain_q;
                3'd2: reg_rdata = addr_q[0];
                3'd3: reg_rdata = ext_q[0];
                3'd4: reg_rdata = addr_q[1];
                3'd5: reg_rdata = ext_q[1];
                3'd6: reg_rdata = {{(DW-2){1'b0}}, stat_q};
                default: reg_rdata = '0;
            endcase
        end
    end

    // Bus cycle outputs derived from the sequencer state.
    always_comb begin
        bus_req   = (state_q == ST_XFER) || (state_q == ST_SRC) || (state_q == ST_DST);
        bus_we    = (state_q == ST_XFER) ? mode_q[11] : (state_q == ST_DST);
        bus_io    = (state_q == ST_SRC) ? xm[1] : ((state_q == ST_DST) && xm[0]);
        bus_addr  = (state_q == ST_DST) ? addr_q[1] : addr_q[0];
        bus_wdata = hold_q;
    end

    // Sequencer and channel registers; host writes are applied last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            remain_q <= '0;
            hold_q   <= '0;
            addr_q[0] <= '0; addr_q[1] <= '0;
            ext_q[0]  <= '0; ext_q[1]  <= '0;
            stat_q   <= '0;
            pair_q   <= 1'b0;
            seen_q   <= 1'b0;
            fidx_q   <= '0;
            fptr_q   <= '0;
        end else begin
            case (state_q)
                ST_ARM: begin
                    if (blk_end) begin
                        if (chain_ok) begin
                            state_q <= ST_FETCH;
                            fidx_q  <= '0;
                            fptr_q  <= mode_q[5:0];
                        end else begin
                            state_q    <= ST_IDLE;
                            mode_q[15] <= 1'b0;
                            stat_q[1]  <= 1'b1;
                        end
                    end else if (area_x) begin
                        state_q <= ST_SRC;
                    end else if (dev_req || (xm == XM_BURST && seen_q)) begin
                        state_q <= ST_XFER;
                        seen_q  <= 1'b1;
                        pair_q  <= 1'b0;
                    end
                end
                ST_XFER: if (bus_ack) begin
                    addr_q[0] <= addr_nx[0];
                    remain_q  <= remain_q - DW'(1);
                    if (!mode_q[11]) hold_q <= bus_rdata;
                    if (xm == XM_DOUBLE && !pair_q && remain_q != DW'(1))
                        pair_q <= 1'b1;
                    else if (!(xm == XM_BURST && remain_q != DW'(1)))
                        state_q <= ST_ARM;
                end
                ST_SRC: if (bus_ack) begin
                    hold_q    <= bus_rdata;
                    addr_q[0] <= addr_nx[0];
                    state_q   <= ST_DST;
                end
                ST_DST: if (bus_ack) begin
                    addr_q[1] <= addr_nx[1];
                    remain_q  <= remain_q - DW'(1);
                    state_q   <= ST_ARM;
                end
                ST_FETCH: begin
                    if (fetch_bad) begin
                        stat_q[0]  <= 1'b1;
                        mode_q[15] <= 1'b0;
                        state_q    <= ST_IDLE;
                    end else begin
                        case (fidx_q)
                            FI_W'(0): mode_q    <= {1'b1, fetch_data[14:0]};
                            FI_W'(1): remain_q  <= fetch_data;
                            FI_W'(2): addr_q[0] <= fetch_data;
                            FI_W'(3): ext_q[0]  <= fetch_data;
                            FI_W'(4): addr_q[1] <= fetch_data;
                            default:  ext_q[1]  <= fetch_data;
                        endcase
                        fidx_q <= fidx_q + FI_W'(1);
                        if (fidx_q == LAST_FI) begin
                            seen_q <= 1'b0;
                            if (xm == XM_NONE) begin
                                mode_q[15] <= 1'b0;
                                state_q    <= ST_IDLE;
                            end else begin
                                state_q <= ST_ARM;
                            end
                        end
                    end
                end
                default: ;
            endcase

            if (reg_we && !is_store && ctrl_off[REG_AW-1:3] == '0) begin
                case (ctrl_off[2:0])
                    3'd0: begin
                        mode_q  <= {start_ok, reg_wdata[14:0]};
                        state_q <= start_ok ? ST_ARM : ST_IDLE;
                        seen_q  <= 1'b0;
                        pair_q  <= 1'b0;
                        if (start_ok) stat_q <= '0;
                    end
                    3'd1: remain_q  <= reg_wdata;
                    3'd2: addr_q[0] <= reg_wdata;
                    3'd3: ext_q[0]  <= reg_wdata;
                    3'd4: addr_q[1] <= reg_wdata;
                    3'd5: ext_q[1]  <= reg_wdata;
                    3'd6: stat_q    <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/chain_dma_chan_chk.sv
// Protocol checker for the chained DMA channel, bound to the top module.
// Assumes: active is mode bit 15 and remain is the remaining-word count.
module chain_dma_chan_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          eot,
    input logic          active,
    input logic [DW-1:0] remain
);
    // R2: bus cycles are only requested while the channel is active.
    a_r2_req_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> active);

    // R7: the end-of-transfer strobe lasts a single cycle.
    a_r7_eot_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);

    // R7: end of transfer only when the count is exhausted.
    a_r7_eot_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> remain == '0);

    // R7: the cycle after the strobe is a fetch or idle, never a bus cycle.
    a_r7_eot_no_bus_next: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !bus_req);
endmodule

bind chain_dma_chan chain_dma_chan_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .eot(eot),
    .active(mode_q[15]), .remain(remain_q)
);

// File: tb/chain_dma_chan_test.sv
// Scoreboard bench: tasks queue the expected bus cycles, and a monitor acting
// as the bus responder compares each request against the queue head.
module chain_dma_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wpar = 1'b0;
    logic [15:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic        bus_req, bus_we, bus_io, eot;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int eot_cnt = 0;
    int xfer_cnt = 0;

    typedef struct packed {
        logic        we;
        logic        io;
        logic [15:0] addr;
        logic        chk_wd;
        logic [15:0] wd;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    assign bus_rdata = bus_addr ^ 16'h5A5A;

    chain_dma_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_wpar(reg_wpar), .reg_rdata(reg_rdata),
        .dev_req(dev_req), .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .eot(eot)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor / responder: acknowledges each request and scores it.
    always @(negedge clk) begin
        if (!rst_n) bus_ack = 1'b0;
        else if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            xfer_cnt++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2/R3 unexpected bus cycle: actual addr=%h expected none", bus_addr);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check("R3/R6 bus_we", {15'd0, bus_we}, {15'd0, e.we});
                check("R6 bus_io", {15'd0, bus_io}, {15'd0, e.io});
                check("R3/R6 bus_addr", bus_addr, e.addr);
                if (e.chk_wd) check("R6 bus_wdata", bus_wdata, e.wd);
            end
            bus_ack = 1'b1;
        end
        if (rst_n && eot) eot_cnt++;
    end

    task automatic push(input logic we, input logic io, input logic [15:0] a,
                        input logic chk, input logic [15:0] wd);
        exp_q.push_back('{we: we, io: io, addr: a, chk_wd: chk, wd: wd});
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic p);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wpar = p; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse_req();
        @(negedge clk); dev_req = 1'b1;
        @(negedge clk); dev_req = 1'b0;
    endtask

    task automatic drain(input int extra);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    task automatic setup(input logic [15:0] cnt, input logic [15:0] a1, input logic [15:0] a2);
        wr(9'h1E1, cnt, 1'b0);
        wr(9'h1E2, a1, 1'b0);
        wr(9'h1E4, a2, 1'b0);
    endtask

    task automatic put_instr(input int idx, input logic [15:0] m, input logic [15:0] cnt,
                             input logic [15:0] a1, input logic [15:0] a2, input int bad_word);
        logic [15:0] w [6];
        w[0] = m; w[1] = cnt; w[2] = a1; w[3] = 16'h0; w[4] = a2; w[5] = 16'h0;
        for (int i = 0; i < 6; i++)
            wr(9'(idx * 8 + i), w[i], (^w[i]) ^ (i == bad_word));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : main
        int e0;
        int x0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 mode after reset", 9'h1E0, 16'h0000);
        rd_chk("R1 status after reset", 9'h1E6, 16'h0000);
        check("R1 bus_req/eot low", {14'd0, bus_req, eot}, 16'h0);

        // R10 window
        wr(9'h005, 16'h1234, ^16'h1234);
        rd_chk("R10 store readback", 9'h005, 16'h1234);
        wr(9'h1DF, 16'hBEEF, ^16'hBEEF);
        rd_chk("R10 last store word", 9'h1DF, 16'hBEEF);
        rd_chk("R10 unused word reads 0", 9'h1E8, 16'h0000);
        wr(9'h1E3, 16'h00A7, 1'b0);
        rd_chk("R10 area1 extension", 9'h1E3, 16'h00A7);

        // R2 reserved transfer mode 011 does not start
        setup(16'd2, 16'h0040, 16'h0);
        wr(9'h1E0, 16'hB03F, 1'b0);
        repeat (4) @(negedge clk);
        rd_chk("R2 mode 011 stays inactive", 9'h1E0, 16'h303F);
        check("R2 no bus cycle for mode 011", 16'(xfer_cnt), 16'd0);

        // R3 single read incrementing, R7 end without chaining
        setup(16'd3, 16'h0100, 16'h0);
        wr(9'h1E0, 16'h803F, 1'b0);
        rd_chk("R2 started channel reads active", 9'h1E0, 16'h803F);
        e0 = eot_cnt;
        push(0, 0, 16'h0100, 0, 0);
        pulse_req(); drain(6);
        check("R3 one cycle per request", 16'(xfer_cnt), 16'd1);
        push(0, 0, 16'h0101, 0, 0); pulse_req(); drain(3);
        push(0, 0, 16'h0102, 0, 0); pulse_req(); drain(4);
        check("R7 eot once at end", 16'(eot_cnt - e0), 16'd1);
        rd_chk("R7 active cleared", 9'h1E0, 16'h003F);
        rd_chk("R7 status done bit", 9'h1E6, 16'h0002);
        rd_chk("R3 remaining zero", 9'h1E1, 16'h0000);

        // R3 single write decrementing
        setup(16'd2, 16'h0200, 16'h0);
        wr(9'h1E0, 16'h8C3F, 1'b0);
        push(1, 0, 16'h0200, 0, 0); pulse_req(); drain(3);
        push(1, 0, 16'h01FF, 0, 0); pulse_req(); drain(4);
        rd_chk("R3 area1 after two decrements", 9'h1E2, 16'h01FE);

        // R4 double
        setup(16'd4, 16'h0300, 16'h0);
        wr(9'h1E0, 16'h903F, 1'b0);
        push(0, 0, 16'h0300, 0, 0); push(0, 0, 16'h0301, 0, 0);
        pulse_req(); drain(6);
        rd_chk("R4 remaining drops by two", 9'h1E1, 16'd2);
        push(0, 0, 16'h0302, 0, 0); push(0, 0, 16'h0303, 0, 0);
        pulse_req(); drain(4);
        rd_chk("R4 ends after second pair", 9'h1E0, 16'h103F);

        // R5 burst read decrementing
        setup(16'd4, 16'h0400, 16'h0);
        wr(9'h1E0, 16'hA43F, 1'b0);
        push(0, 0, 16'h0400, 0, 0); push(0, 0, 16'h03FF, 0, 0);
        push(0, 0, 16'h03FE, 0, 0); push(0, 0, 16'h03FD, 0, 0);
        pulse_req(); drain(4);
        rd_chk("R5 burst completed block", 9'h1E1, 16'd0);

        // R6 area to area, IO to memory, area1 inc, area2 dec
        setup(16'd2, 16'h0010, 16'h0050);
        push(0, 1, 16'h0010, 0, 0); push(1, 0, 16'h0050, 1, 16'h0010 ^ 16'h5A5A);
        push(0, 1, 16'h0011, 0, 0); push(1, 0, 16'h004F, 1, 16'h0011 ^ 16'h5A5A);
        wr(9'h1E0, 16'hE63F, 1'b0);
        drain(4);
        rd_chk("R6 area2 decremented", 9'h1E4, 16'h004E);

        // R6 memory to IO with both addresses held
        setup(16'd2, 16'h0020, 16'h0060);
        push(0, 0, 16'h0020, 0, 0); push(1, 1, 16'h0060, 1, 16'h0020 ^ 16'h5A5A);
        push(0, 0, 16'h0020, 0, 0); push(1, 1, 16'h0060, 1, 16'h0020 ^ 16'h5A5A);
        wr(9'h1E0, 16'hD33F, 1'b0);
        drain(4);
        rd_chk("R6 area1 held", 9'h1E2, 16'h0020);

        // R8 chaining to instruction 2, R7 eot only at final block
        put_instr(2, 16'hC53F, 16'd1, 16'h0700, 16'h0800, -1);
        setup(16'd1, 16'h0600, 16'h0680);
        e0 = eot_cnt;
        push(0, 0, 16'h0600, 0, 0); push(1, 0, 16'h0680, 1, 16'h0600 ^ 16'h5A5A);
        push(0, 0, 16'h0700, 0, 0); push(1, 0, 16'h0800, 1, 16'h0700 ^ 16'h5A5A);
        wr(9'h1E0, 16'hC542, 1'b0);
        drain(6);
        check("R7 chained block gives no eot", 16'(eot_cnt - e0), 16'd1);
        rd_chk("R8 loaded mode", 9'h1E0, 16'h453F);
        rd_chk("R8 loaded area1 stepped", 9'h1E2, 16'h0701);
        rd_chk("R8 loaded area2 stepped", 9'h1E4, 16'h0801);

        // R7 forced eot while chaining
        setup(16'd1, 16'h0600, 16'h0680);
        e0 = eot_cnt;
        push(0, 0, 16'h0600, 0, 0); push(1, 0, 16'h0680, 1, 16'h0600 ^ 16'h5A5A);
        push(0, 0, 16'h0700, 0, 0); push(1, 0, 16'h0800, 1, 16'h0700 ^ 16'h5A5A);
        wr(9'h1E0, 16'hC5C2, 1'b0);
        drain(6);
        check("R7 forced eot on both blocks", 16'(eot_cnt - e0), 16'd2);

        // R8 reserved pointer 0x3C stops
        setup(16'd1, 16'h0620, 16'h0690);
        e0 = eot_cnt;
        push(0, 0, 16'h0620, 0, 0); push(1, 0, 16'h0690, 1, 16'h0620 ^ 16'h5A5A);
        wr(9'h1E0, 16'hC57C, 1'b0);
        drain(8);
        check("R8 reserved pointer ends run", 16'(eot_cnt - e0), 16'd1);
        rd_chk("R8 reserved pointer inactive", 9'h1E0, 16'h457C);

        // R8 chain bit 0 overrides a valid pointer
        setup(16'd1, 16'h0630, 16'h06A0);
        push(0, 0, 16'h0630, 0, 0); push(1, 0, 16'h06A0, 1, 16'h0630 ^ 16'h5A5A);
        wr(9'h1E0, 16'hC502, 1'b0);
        drain(8);
        rd_chk("R8 chain disabled, no load", 9'h1E0, 16'h4502);

        // R9 parity fault on instruction 3 word 1
        put_instr(3, 16'hC53F, 16'd1, 16'h0A00, 16'h0B00, 1);
        setup(16'd1, 16'h0900, 16'h0980);
        e0 = eot_cnt;
        push(0, 0, 16'h0900, 0, 0); push(1, 0, 16'h0980, 1, 16'h0900 ^ 16'h5A5A);
        wr(9'h1E0, 16'hC543, 1'b0);
        drain(10);
        rd_chk("R9 error status", 9'h1E6, 16'h0001);
        rd_chk("R9 active cleared", 9'h1E0, 16'h453F);
        check("R9 no eot on fault", 16'(eot_cnt - e0), 16'd0);

        // R2 stop by writing bit 15 low
        setup(16'd5, 16'h0B00, 16'h0);
        wr(9'h1E0, 16'h803F, 1'b0);
        push(0, 0, 16'h0B00, 0, 0); pulse_req(); drain(3);
        wr(9'h1E0, 16'h003F, 1'b0);
        x0 = xfer_cnt;
        pulse_req(); repeat (6) @(negedge clk);
        check("R2 stopped channel ignores request", 16'(xfer_cnt - x0), 16'd0);
        rd_chk("R2 remaining kept after stop", 9'h1E1, 16'd4);
        check("R3 scoreboard empty", 16'(exp_q.size()), 16'd0);

        summary();
        $finish;
    end
endmodule